// File: doc/BRIEF.md
# Eight-Channel Pad Event Interrupt Unit

This block watches up to eight pads out of a 64-pad space and turns activity on them into eight separate interrupt lines. Each channel has its own pad selector, so any pad can feed any channel, and several channels may watch the same pad. A channel reacts to rising edges, falling edges, both edges, or a steady high or low level. The selected pad is brought into the clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized sample with the one taken a cycle earlier.

Software drives the unit through a small word-addressed register bus with a single write strobe and a combinational read port. The two enable vectors cannot be written directly. Each has a set port and a clear port, and in both a 1 bit acts while a 0 bit is ignored, so concurrent drivers never need a read-modify-write sequence. Edge events are latched in rising and falling status vectors whether or not the channel is enabled. These status bits are cleared by writing 1 to them. In level mode the falling-enable bit selects the active polarity instead, and the interrupt follows the pad with nothing latched.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset the mode, rising-enable, falling-enable, rising-status and falling-status vectors read 0, every selector reads 0, and all interrupt outputs are low.
- R2: Channel i's selector sits at address i (0 to 7) and holds a 6-bit pad index equal to 32 times the bank plus the pin number. The channel observes pads[index].
- R3: A write to address 9 (rising-enable set) or address 11 (falling-enable set) sets each enable bit whose data bit is 1 and leaves the bits written 0 unchanged. Reading either address of a pair returns that enable vector, with bit i belonging to channel i.
- R4: A write to address 10 (rising-enable clear) or address 12 (falling-enable clear) clears each enable bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: A rising edge on a channel's synchronized pad sets its bit in the rising status (address 13), and a falling edge sets its bit in the falling status (address 14). This happens regardless of the enables and the mode.
- R6: Writing to a status address clears each bit written 1 and keeps each bit written 0.
- R7: In edge mode, interrupt i is high exactly while (rising status i AND rising enable i) OR (falling status i AND falling enable i). Setting both enables gives both-edge detection.
- R8: In level mode, interrupt i is high while rising enable i is 1 and the synchronized pad equals falling enable i (1 = active high, 0 = active low). The interrupt drops as soon as the level goes away.
- R9: The mode vector at address 8 is written directly. Bit i = 1 puts channel i in level mode, and 0 puts it in edge mode.
- R10: A pad change made between clock edges shows in the status after the third following rising clock edge, and in a level-mode interrupt after the second.
- R11: With both enable bits of a channel cleared, its interrupt stays low in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads | input | 64 | Pad levels, asynchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 8 | Per-channel interrupt lines |

## Verification
The bench counts clock edges from a pad change to the status bit and to the level interrupt. A design with one synchronizer stage too many or too few misses these cycles. It writes zero words to the set, clear and status ports, which catches a design that treats these ports as plain registers by wiping bits. It drives a level-mode channel low after it fired and expects the line to drop at once. A design that latched level events would hold the interrupt high. A long random run compares both status vectors and all interrupt lines against a bench model, and exposes a swapped polarity, a misrouted selector or a status bit that does not latch.

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
  parameter int NUM_CH   = 8,
  parameter int NUM_PADS = 64,
  parameter int AW       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PADS-1:0]  pads,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [((NUM_CH > $clog2(NUM_PADS)) ? NUM_CH : $clog2(NUM_PADS))-1:0] bus_wdata,
  output logic [((NUM_CH > $clog2(NUM_PADS)) ? NUM_CH : $clog2(NUM_PADS))-1:0] bus_rdata,
  output logic [NUM_CH-1:0]    irq
);
  localparam int SEL_W = $clog2(NUM_PADS);
  localparam int DW = (NUM_CH > SEL_W) ? NUM_CH : SEL_W;
  localparam logic [AW-1:0] A_MODE = AW'(NUM_CH);
  localparam logic [AW-1:0] A_RSET = AW'(NUM_CH + 1);
  localparam logic [AW-1:0] A_RCLR = AW'(NUM_CH + 2);
  localparam logic [AW-1:0] A_FSET = AW'(NUM_CH + 3);
  localparam logic [AW-1:0] A_FCLR = AW'(NUM_CH + 4);
  localparam logic [AW-1:0] A_RST  = AW'(NUM_CH + 5);
  localparam logic [AW-1:0] A_FST  = AW'(NUM_CH + 6);

  logic [SEL_W-1:0]  sel [NUM_CH];
  logic [NUM_CH-1:0] mode, ren, fen, rdet, fdet;
  logic [NUM_CH-1:0] picked, s1, s2, s3, rise, fall, w;

  assign w = bus_wdata[NUM_CH-1:0];

  always_comb
    for (int i = 0; i < NUM_CH; i++) picked[i] = pads[sel[i]];

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) sel[i] <= '0;
      {s1, s2, s3} <= '0;
      {mode, ren, fen, rdet, fdet} <= '0;
    end else begin
      s1 <= picked;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < NUM_CH; i++)
        if (bus_we && bus_addr == AW'(i)) sel[i] <= bus_wdata[SEL_W-1:0];
      if (bus_we && bus_addr == A_MODE) mode <= w;
      if (bus_we && bus_addr == A_RSET) ren <= ren | w;
      else if (bus_we && bus_addr == A_RCLR) ren <= ren & ~w;
      if (bus_we && bus_addr == A_FSET) fen <= fen | w;
      else if (bus_we && bus_addr == A_FCLR) fen <= fen & ~w;
      rdet <= (rdet & ~((bus_we && bus_addr == A_RST) ? w : '0)) | rise;
      fdet <= (fdet & ~((bus_we && bus_addr == A_FST) ? w : '0)) | fall;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr == AW'(i)) bus_rdata = DW'(sel[i]);
    case (bus_addr)
      A_MODE:         bus_rdata = DW'(mode);
      A_RSET, A_RCLR: bus_rdata = DW'(ren);
      A_FSET, A_FCLR: bus_rdata = DW'(fen);
      A_RST:          bus_rdata = DW'(rdet);
      A_FST:          bus_rdata = DW'(fdet);
      default: ;
    endcase
  end

  assign irq = (~mode & ((rdet & ren) | (fdet & fen))) | (mode & ren & ~(s2 ^ fen));

  // R3
  rset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_RSET) |=>
      ((ren & $past(w)) == $past(w)) && (($past(ren) & ~ren) == '0));
  // R4
  rclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_RCLR) |=>
      ((ren & $past(w)) == '0) && ((ren & ~$past(ren)) == '0));
  // R5
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdet & ~$past(rdet) & ~$past(rise)) == '0) &&
             ((fdet & ~$past(fdet) & ~$past(fall)) == '0));
  // R7
  edge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~mode & ~(rdet | fdet)) == '0);
  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(ren | fen)) == '0);
endmodule

// File: tb/sim_pin_irq_unit.sv
module sim_pin_irq_unit;
  localparam logic [3:0] A_MODE = 8, A_RSET = 9, A_RCLR = 10, A_FSET = 11,
                         A_FCLR = 12, A_RST = 13, A_FST = 14;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [63:0] pads = '0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pin_irq_unit u0 (.clk(clk), .rst_n(rst_n), .pads(pads), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    pads = '0; rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  function automatic logic [7:0] irq_model(input logic [7:0] md, re, fe, rs, fs,
                                           input logic [7:0] lv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = md[i] ? (re[i] & (lv[i] == fe[i])) : ((rs[i] & re[i]) | (fs[i] & fe[i]));
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [5:0] sl [8];
    logic [7:0] md, re, fe, rs, fs, lv, msk;
    logic [63:0] np;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int a = 0; a < 15; a++) begin rd(a[3:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq", irq, 0);

    // R2 selectors
    wr(0, 6'd5); wr(1, 6'd35); wr(7, 6'd63);
    rd(0, d); chk("R2 sel0", d, 5);
    rd(1, d); chk("R2 sel1", d, 35);
    rd(7, d); chk("R2 sel7", d, 63);

    // R3 / R4 set and clear ports
    wr(A_RSET, 8'h03); wr(A_RSET, 8'h00);
    rd(A_RSET, d); chk("R3 rise set", d, 8'h03);
    wr(A_FSET, 8'h02); rd(A_FCLR, d); chk("R3 fall set", d, 8'h02);
    wr(A_RCLR, 8'h00); rd(A_RCLR, d); chk("R4 zero clear", d, 8'h03);
    wr(A_RCLR, 8'h02); rd(A_RSET, d); chk("R4 rise clear", d, 8'h01);
    wr(A_FCLR, 8'h02); rd(A_FSET, d); chk("R4 fall clear", d, 8'h00);

    // R10 edge latency, R7 edge irq on ch0 (pad 5)
    pads[5] = 1;
    cyc(2); rd(A_RST, d); chk("R10 not yet", d, 0);
    cyc(1); rd(A_RST, d); chk("R10 rise latched", d, 8'h01);
    chk("R7 irq ch0", irq, 8'h01);

    // R6 status clear
    wr(A_RST, 8'h00); rd(A_RST, d); chk("R6 zero write keeps", d, 8'h01);
    wr(A_RST, 8'h01); rd(A_RST, d); chk("R6 clear", d, 8'h00);
    chk("R7 irq dropped", irq, 0);

    // R2 bank 1 routing, R5 latch without enable (ch1 pad 35, enables 0)
    pads[35] = 1; cyc(4);
    rd(A_RST, d); chk("R5 rise no enable", d, 8'h02);
    chk("R5 irq quiet", irq, 0);
    pads[35] = 0; cyc(4);
    rd(A_FST, d); chk("R5 fall latched", d, 8'h02);
    wr(A_RST, 8'hff); wr(A_FST, 8'hff);

    // R7 both edges on ch3 (pad 40)
    wr(3, 6'd40); wr(A_RSET, 8'h08); wr(A_FSET, 8'h08);
    pads[40] = 1; cyc(4); chk("R7 both rise", irq[3], 1);
    wr(A_RST, 8'h08); chk("R7 cleared", irq[3], 0);
    pads[40] = 0; cyc(4); chk("R7 both fall", irq[3], 1);
    wr(A_FST, 8'h08);
    // R11 disable
    pads[40] = 1; cyc(4);
    wr(A_RCLR, 8'h08); wr(A_FCLR, 8'h08);
    chk("R11 disabled", irq[3], 0);
    wr(A_RST, 8'hff); wr(A_FST, 8'hff);

    // R9 / R8 level mode on ch2 (pad 10)
    wr(2, 6'd10); wr(A_MODE, 8'h04); rd(A_MODE, d); chk("R9 mode", d, 8'h04);
    wr(A_RSET, 8'h04); wr(A_FSET, 8'h04);
    pads[10] = 1;
    cyc(1); chk("R10 level early", irq[2], 0);
    cyc(1); chk("R10 level on", irq[2], 1);
    pads[10] = 0; cyc(3); chk("R8 not latched", irq[2], 0);
    wr(A_FCLR, 8'h04); cyc(1); chk("R8 active low", irq[2], 1);
    wr(A_RCLR, 8'h04); chk("R11 level off", irq[2], 0);

    // random phase
    do_reset();
    for (int i = 0; i < 8; i++) begin sl[i] = 6'($urandom); wr(i[3:0], 8'(sl[i])); end
    md = 8'($urandom); re = 8'($urandom); fe = 8'($urandom);
    wr(A_MODE, md); wr(A_RSET, re); wr(A_FSET, fe);
    rs = 0; fs = 0; lv = 0;
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        msk = 8'($urandom); wr(A_RST, msk); rs &= ~msk;
        msk = 8'($urandom); wr(A_FST, msk); fs &= ~msk;
      end
      if ($urandom_range(0, 9) == 0) begin
        msk = 8'($urandom); wr(A_RSET, msk); re |= msk;
        msk = 8'($urandom); wr(A_FCLR, msk); fe &= ~msk;
        msk = 8'($urandom); wr(A_MODE, msk); md = msk;
        msk = 8'($urandom); wr(A_FSET, msk); fe |= msk;
        msk = 8'($urandom); wr(A_RCLR, msk); re &= ~msk;
      end
      np = {$urandom, $urandom};
      pads = np;
      for (int c = 0; c < 8; c++) begin
        rs[c] = rs[c] | (np[sl[c]] & ~lv[c]);
        fs[c] = fs[c] | (~np[sl[c]] & lv[c]);
        lv[c] = np[sl[c]];
      end
      cyc(4);
      rd(A_RST, d); chk("R5 rand rise", d, rs);
      rd(A_FST, d); chk("R5 rand fall", d, fs);
      chk("R7 R8 rand irq", irq, irq_model(md, re, fe, rs, fs, lv));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule